// File: doc/BRIEF.md
# Status Register Write-Protect Guard

This block sits between the command decoder of a serial flash device and its status register. It decides the fate of each status-register write. The decoder raises a one-cycle request, carrying the new value, once it has received a complete status-write command while chip-select is low. The guard then watches the write-protect pin and the chip-select pin. It ends each write in exactly one of three ways: the write is refused at once, it is cancelled part-way through, or it is committed when chip-select is released.

Protection depends on a protect-enable bit held in the status register itself. While that bit is clear, the pin has no effect, so a board may tie the pin low and still write the register. While the bit is set and the pin is low, a write is refused or cancelled. A committed write starts a timed internal cycle, and the new value lands when that cycle ends. From the moment of commit, the pin no longer affects the write. The block also decodes the protect-level field of the register into one read-only flag per memory region.

Top module: `sr_wp_guard`

## Requirements
- R1: After reset, `sr_q` is all zeros, `busy` is 0, all three outcome pulses are 0 and `lock_ro` is all zeros.
- R2: With `wp_n` high, a request followed by `cs_n` going high gives exactly one `wr_commit` pulse. `busy` is then set, and when `busy` clears, `sr_q` equals the requested value.
- R3: If `sr_q[7]` (protect-enable) is 1 and `wp_n` is low on the request cycle, the write is refused. `wr_blocked` pulses for one cycle in the next cycle, `busy` stays 0 and `sr_q` is unchanged.
- R4: While `sr_q[7]` is 0, the level of `wp_n` at any point of a write has no effect, and the write commits.
- R5: If `sr_q[7]` is 1 and `wp_n` is seen low after an accepted request, the write is cancelled. This covers any cycle in which `cs_n` is low, and also the cycle in which `cs_n` returns high. `wr_aborted` pulses once, `busy` stays 0 and `sr_q` is unchanged.
- R6: Once `wr_commit` has pulsed, changes of `wp_n` have no effect, and the requested value is written.
- R7: `busy` stays high for exactly `WR_CYCLES` clock cycles, and `sr_q` holds still while it is high. Requests that arrive while `busy` is high cause no outcome pulse and do not change the value that is written.
- R8: Let bp = `sr_q[3:2]`, and let n = 4 when bp is 3, otherwise n = bp. Then `lock_ro[i]` is 1 exactly when i >= 4 - n. Region 3 is the highest address range.
- R9: At most one outcome pulse is high in any cycle, and each accepted request produces exactly one of them.
- R10: Protection is judged from the protect-enable bit already held in `sr_q`, not from the value being written. With the bit clear and `wp_n` low, a write that sets the bit commits. The next write under a low `wp_n` is then refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low, already synchronised |
| wp_n | input | 1 | Write-protect pin, active low, already synchronised |
| sr_wr_req | input | 1 | One-cycle request: a complete status-write command has been received |
| sr_wr_data | input | SR_W | Value to be written, valid with `sr_wr_req` |
| sr_q | output | SR_W | Committed status register value |
| busy | output | 1 | Internal write cycle in progress |
| wr_commit | output | 1 | Pulse: the write was committed and the timed cycle started |
| wr_blocked | output | 1 | Pulse: the write was refused at request time |
| wr_aborted | output | 1 | Pulse: the write was cancelled before commit |
| lock_ro | output | NREG | Per-region read-only flags derived from the protect-level field |

## Verification
A wrong guard state shows up at the outcome pulses one cycle after the offending pin sample. A write that is wrongly accepted also raises `busy` on the cycle after `cs_n` rises, where the correct design would have pulsed `wr_aborted`. A timer or latch fault shows up as a `busy` window of the wrong length, or as a wrong `sr_q` on the cycle `busy` clears. A wrong `sr_q` then spreads straight into `lock_ro` and into every later protect decision. The sweep therefore compares `sr_q` and `lock_ro` after every write, and the next write exposes any stale protect-enable bit.

// File: rtl/sr_wp_pkg.sv
// Package: shared types for the status register write-protect guard.
// Assumes: one guard per status register; all inputs are synchronous to clk.
package sr_wp_pkg;

    // Phase of the write handling sequence
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_BUSY  = 2'd2
    } wp_phase_e;

    // Decision taken by the gate for the current cycle
    typedef enum logic [2:0] {
        DEC_NONE   = 3'd0,
        DEC_ARM    = 3'd1,
        DEC_BLOCK  = 3'd2,
        DEC_ABORT  = 3'd3,
        DEC_COMMIT = 3'd4
    } wp_dec_e;

endpackage

// File: rtl/srwp_gate.sv
// Module: srwp_gate
// Purely combinational decision logic. The phase, the request, chip-select,
// the write-protect pin and the committed protect-enable bit together
// choose the action for this cycle.
// Assumes: the request arrives only while chip-select is low; a request with
// chip-select high is ignored.
module srwp_gate
    import sr_wp_pkg::*;
(
    input  wp_phase_e phase,
    input  logic      req,
    input  logic      cs_n,
    input  logic      wp_n,
    input  logic      wpen,
    output wp_dec_e   dec
);

    logic pin_ok;

    // Pin only matters when the protect-enable bit is set
    always_comb pin_ok = wp_n | ~wpen;

    // Choose the action for the current phase
    always_comb begin
        dec = DEC_NONE;
        unique case (phase)
            PH_IDLE: begin
                if (req && !cs_n) begin
                    dec = pin_ok ? DEC_ARM : DEC_BLOCK;
                end
            end
            PH_ARMED: begin
                if (!pin_ok) begin
                    dec = DEC_ABORT;
                end else if (cs_n) begin
                    dec = DEC_COMMIT;
                end
            end
            default: dec = DEC_NONE;
        endcase
    end

endmodule

// File: rtl/srwp_timer.sv
// Module: srwp_timer
// Counts the internal write cycle. A start pulse raises running for exactly
// WR_CYCLES clocks; done is high in the last of them.
// Assumes: start is never raised while running is high.
module srwp_timer #(
    parameter int WR_CYCLES = 16,
    localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Load on start, count down while running, stop after zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            remain  <= '0;
        end else if (start) begin
            running <= 1'b1;
            remain  <= LOAD;
        end else if (running) begin
            if (remain == '0) begin
                running <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    // Final cycle of the window
    always_comb done = running && (remain == '0);

endmodule

// File: rtl/srwp_region_map.sv
// Module: srwp_region_map
// Turns the protect-level field into one read-only flag per region, counted
// from the top. The all-ones level locks every region; any other level b
// locks the b highest regions.
// Assumes: NREG equals 2**BP_W.
module srwp_region_map #(
    parameter int BP_W = 2,
    localparam int NREG = 1 << BP_W
) (
    input  logic [BP_W-1:0] level,
    output logic [NREG-1:0] lock_ro
);

    localparam int SUM_W = BP_W + 2;

    logic [BP_W:0] n_locked;

    // Number of regions locked from the top
    always_comb n_locked = (&level) ? (BP_W+1)'(NREG) : {1'b0, level};

    // One comparator per region
    for (genvar i = 0; i < NREG; i++) begin : g_region
        assign lock_ro[i] = ({1'b0, n_locked} + SUM_W'(i)) >= SUM_W'(NREG);
    end

endmodule

// File: rtl/sr_wp_guard.sv
// Module: sr_wp_guard (top)
// Holds the status register and guards writes to it. An accepted request is
// armed until chip-select rises. The pin is checked each armed cycle,
// including the rise cycle. On commit, the timed cycle runs and the armed
// value lands when it ends. The pin is ignored once the commit has happened.
// Assumes: cs_n and wp_n are synchronised; the decoder pulses sr_wr_req once
// per complete command.
module sr_wp_guard
    import sr_wp_pkg::*;
#(
    parameter int SR_W      = 8,
    parameter int WPEN_POS  = 7,
    parameter int BP_LSB    = 2,
    parameter int BP_W      = 2,
    parameter int WR_CYCLES = 16,
    localparam int NREG     = 1 << BP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            wp_n,
    input  logic            sr_wr_req,
    input  logic [SR_W-1:0] sr_wr_data,
    output logic [SR_W-1:0] sr_q,
    output logic            busy,
    output logic            wr_commit,
    output logic            wr_blocked,
    output logic            wr_aborted,
    output logic [NREG-1:0] lock_ro
);

    wp_phase_e       phase;
    wp_dec_e         dec;
    logic [SR_W-1:0] pend;
    logic            t_start;
    logic            t_done;

    srwp_gate u_gate (
        .phase (phase),
        .req   (sr_wr_req),
        .cs_n  (cs_n),
        .wp_n  (wp_n),
        .wpen  (sr_q[WPEN_POS]),
        .dec   (dec)
    );

    // Timer starts on the commit decision
    always_comb t_start = (dec == DEC_COMMIT);

    srwp_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .running (busy),
        .done    (t_done)
    );

    srwp_region_map #(.BP_W(BP_W)) u_map (
        .level   (sr_q[BP_LSB +: BP_W]),
        .lock_ro (lock_ro)
    );

    // Phase sequencing driven by the gate decision and the timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (dec)
                DEC_ARM:    phase <= PH_ARMED;
                DEC_BLOCK,
                DEC_ABORT:  phase <= PH_IDLE;
                DEC_COMMIT: phase <= PH_BUSY;
                default: begin
                    if (phase == PH_BUSY && t_done) begin
                        phase <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    // Capture the requested value when the write is armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (dec == DEC_ARM) begin
            pend <= sr_wr_data;
        end
    end

    // Register update at the end of the timed cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (t_done) begin
            sr_q <= pend;
        end
    end

    // One-cycle outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_commit  <= 1'b0;
            wr_blocked <= 1'b0;
            wr_aborted <= 1'b0;
        end else begin
            wr_commit  <= (dec == DEC_COMMIT);
            wr_blocked <= (dec == DEC_BLOCK);
            wr_aborted <= (dec == DEC_ABORT);
        end
    end

endmodule

// File: rtl/sr_wp_guard_chk.sv
// Module: sr_wp_guard_chk
// Property checker bound to sr_wp_guard. It sees only the top-level ports and
// measures the busy window with its own counter.
module sr_wp_guard_chk #(
    parameter int SR_W      = 8,
    parameter int WPEN_POS  = 7,
    parameter int WR_CYCLES = 16,
    parameter int NREG      = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            wp_n,
    input logic [SR_W-1:0] sr_q,
    input logic            busy,
    input logic            wr_commit,
    input logic            wr_blocked,
    input logic            wr_aborted,
    input logic [NREG-1:0] lock_ro
);

    localparam int RUN_W = $clog2(WR_CYCLES + 1) + 1;

    logic [RUN_W-1:0] run;

    // Count consecutive sampled busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (busy) begin
            run <= run + 1'b1;
        end else begin
            run <= '0;
        end
    end

    // R9
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_commit, wr_blocked, wr_aborted}));

    // R3
    blocked_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> (!$past(wp_n) && sr_q[WPEN_POS] && !busy));

    // R5
    aborted_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_aborted |-> (!$past(wp_n) && sr_q[WPEN_POS] && !busy));

    // R2
    commit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (busy && $past(cs_n) && ($past(wp_n) || !sr_q[WPEN_POS])));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sr_q));

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run) == RUN_W'(WR_CYCLES - 1)));

    // R8
    lock_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_ro << 1) & ~lock_ro) == '0);

endmodule

bind sr_wp_guard sr_wp_guard_chk #(
    .SR_W      (SR_W),
    .WPEN_POS  (WPEN_POS),
    .WR_CYCLES (WR_CYCLES),
    .NREG      (NREG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .wp_n       (wp_n),
    .sr_q       (sr_q),
    .busy       (busy),
    .wr_commit  (wr_commit),
    .wr_blocked (wr_blocked),
    .wr_aborted (wr_aborted),
    .lock_ro    (lock_ro)
);

// File: tb/tb_sr_wp_guard.sv
// Bench for sr_wp_guard: sweeps every pin pattern over a write, under both
// protect-enable states, and every protect level.
module tb_sr_wp_guard;

    localparam int SR_W = 8;
    localparam int WRC  = 16;
    localparam int NREG = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n = 1'b1;
    logic            wp_n = 1'b1;
    logic            req = 1'b0;
    logic [SR_W-1:0] data = '0;
    logic [SR_W-1:0] sr_q;
    logic            busy, wr_commit, wr_blocked, wr_aborted;
    logic [NREG-1:0] lock_ro;

    int n_chk = 0;
    int n_bad = 0;
    int n_commit = 0, n_block = 0, n_abort = 0;
    logic [SR_W-1:0] exp_sr = '0;

    always #5 clk = ~clk;

    sr_wp_guard #(.WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .sr_wr_req(req), .sr_wr_data(data), .sr_q(sr_q), .busy(busy),
        .wr_commit(wr_commit), .wr_blocked(wr_blocked),
        .wr_aborted(wr_aborted), .lock_ro(lock_ro)
    );

    // Outcome pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_commit += int'(wr_commit);
            n_block  += int'(wr_blocked);
            n_abort  += int'(wr_aborted);
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    function automatic logic [NREG-1:0] lock_model(input logic [SR_W-1:0] s);
        int bp = int'(s[3:2]);
        int n  = (bp == 3) ? 4 : bp;
        logic [NREG-1:0] r = '0;
        for (int i = 0; i < NREG; i++) r[i] = (i >= NREG - n);
        return r;
    endfunction

    // One write: pin level at request, in the armed window and at the cs rise
    task automatic do_write(input logic [SR_W-1:0] d, input bit wq, input bit wm,
                            input bit wr, input string rq);
        int c0 = n_commit, b0 = n_block, a0 = n_abort;
        bit wpen = exp_sr[7];
        int outc;   // 0 commit, 1 block, 2 abort
        int bcnt = 0;
        if (!(wq | !wpen))      outc = 1;
        else if (!(wm | !wpen)) outc = 2;
        else if (!(wr | !wpen)) outc = 2;
        else                    outc = 0;
        @(negedge clk); cs_n = 1'b0; wp_n = wq; req = 1'b1; data = d;
        @(negedge clk); req = 1'b0; wp_n = wm;
        @(negedge clk);
        @(negedge clk); wp_n = wr; cs_n = 1'b1;
        @(negedge clk);
        if (outc == 0) begin
            // R6 R7: disturb the pin and send a stray request while busy
            wp_n = 1'b0; cs_n = 1'b0; req = 1'b1; data = ~d;
        end
        for (int k = 0; k < 4 * WRC; k++) begin
            if (busy) bcnt++;
            if (k == 1) begin req = 1'b0; cs_n = 1'b1; end
            @(negedge clk);
        end
        wp_n = 1'b1;
        if (outc == 0) exp_sr = d;
        check((n_commit - c0) == (outc == 0 ? 1 : 0) && (n_block - b0) == (outc == 1 ? 1 : 0)
              && (n_abort - a0) == (outc == 2 ? 1 : 0), rq, "outcome R9",
              (n_commit - c0) * 100 + (n_block - b0) * 10 + (n_abort - a0),
              (outc == 0) ? 100 : (outc == 1) ? 10 : 1);
        check(bcnt == ((outc == 0) ? WRC : 0), "R7", "busy cycles", bcnt, (outc == 0) ? WRC : 0);
        check(sr_q == exp_sr, rq, "sr_q", int'(sr_q), int'(exp_sr));
        check(lock_ro == lock_model(exp_sr), "R8", "lock_ro", int'(lock_ro), int'(lock_model(exp_sr)));
    endtask

    // Watchdog: a hung run is a failed check and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sr_q == '0 && !busy && !wr_commit && !wr_blocked && !wr_aborted && lock_ro == '0,
              "R1", "reset state", int'({sr_q, busy, lock_ro}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sr_q == '0 && !busy && lock_ro == '0, "R1", "after release", int'({sr_q, busy}), 0);

        // R2: plain write with the pin high
        do_write(8'h35, 1'b1, 1'b1, 1'b1, "R2");
        // R10: protect-enable written under a low pin commits, then blocks
        do_write(8'h84, 1'b0, 1'b0, 1'b0, "R10");
        do_write(8'h11, 1'b0, 1'b1, 1'b1, "R10");
        do_write(8'h00, 1'b1, 1'b1, 1'b1, "R2");

        // Sweep all pin patterns under both protect-enable states
        for (int en = 0; en < 2; en++) begin
            for (int p = 0; p < 8; p++) begin
                logic [SR_W-1:0] d;
                string rq;
                d = {exp_sr[7], 7'(p * 9 + en * 3 + 1)};
                if (en == 0)      rq = "R4";
                else if (!p[2])   rq = "R3";
                else              rq = "R5";
                do_write(d, p[2], p[1], p[0], rq);
            end
            // Set protect-enable for the second pass
            do_write(8'h80, 1'b1, 1'b1, 1'b1, "R2");
        end

        // R6: committed writes under protect, then pin toggled while busy
        do_write(8'hA8, 1'b1, 1'b1, 1'b1, "R6");

        // R8: every protect level, with protect-enable cleared at the end
        for (int bp = 0; bp < 4; bp++) begin
            do_write(SR_W'(bp << 2), 1'b1, 1'b1, 1'b1, "R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule